// File: doc/BRIEF.md
# Boot Shadow Controller

After a system reset, a CPU board has to fetch its first instructions from its own onboard ROM, even though other memory cards on the shared bus decode the same addresses. This block drives the active-low bus phantom line that tells those other cards to stay off the bus. A one-way hold flag is set by reset. While the flag is set, the phantom line is pulled low. The flag is cleared by the first qualified memory request that decodes into the onboard device window. It then stays cleared until the next reset, and from that point only the per-access shadow request input can pull the line.

The phantom line is never driven high. When the block is not asserting it, the output enable drops so that the bus driver goes to high impedance and other cards can still use the line. The memory-request strobe arrives asynchronously. It is synchronised to the system clock and its edges are detected internally.

A parameter selects whether the clear happens at the start of the onboard access or at its end. Clearing at the end keeps foreign memory shadowed for the whole first onboard cycle. A second parameter disables the reset-set behaviour entirely.

Top module: `boot_shadow_ctrl`

## Requirements
- R1: With RESET_SETS=1, while `rst` is high and in the first cycle after it falls, `phantom_oe`=1 and `phantom_n`=0.
- R2: With CLR_POINT=CLR_AT_START, a qualified access clears the hold flag. The access is qualified when `mreq_n` goes low, `win_sel`=1 and `addr[15:13]` equals `WIN_BASE[15:13]`. Ports show the clear after the third rising edge after `mreq_n` falls, and not before.
- R3: An access does not clear the hold flag if its address lies outside the window or if it is made with `win_sel`=0.
- R4: Once cleared, the hold flag stays cleared through further qualified accesses; only reset sets it again.
- R5: `phantom_oe` is 1 in every cycle in which `shadow_req`=1, whatever the state of the hold flag. When the flag is clear, `phantom_oe` follows `shadow_req` in the same cycle.
- R6: `phantom_n` is 0 whenever `phantom_oe`=1 and is 1 (released level) whenever `phantom_oe`=0.
- R7: With CLR_POINT=CLR_AT_END, the hold flag stays set for the whole access. It clears after the third rising edge after `mreq_n` rises. The window decision is taken from the address at the start of the access.
- R8: With RESET_SETS=0, the hold flag is never set and `phantom_oe` equals `shadow_req`.
- R9: If the clearing access happens while `shadow_req`=1, `phantom_oe` stays 1 without a gap. It drops as soon as `shadow_req` falls.
- R10: With the default base 0xE000, address 0xDFFF does not match the window, while 0xE000 and 0xFFFF do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset; sets the hold flag |
| mreq_n | input | 1 | Asynchronous active-low memory-request strobe |
| addr | input | ADDR_W | Address bus |
| win_sel | input | 1 | Enables decoding of the onboard device window |
| shadow_req | input | 1 | Per-access request to assert phantom |
| phantom_n | output | 1 | Level presented to the bus driver (0 when asserting) |
| phantom_oe | output | 1 | Output enable for the tristate phantom driver |

## Verification
Two functions can act in the same cycle: clearing the hold flag and asserting phantom through the per-access request. The bench holds `shadow_req` high across a whole qualified access, including the clear edge, in both clear-point variants. It judges the outcome at the ports. The enable must not dip at any sampled cycle, and it must drop in the very cycle the request is released, which shows that the flag was cleared underneath it.

// File: rtl/boot_shadow_pkg.sv
package boot_shadow_pkg;

    // Where in the first onboard access the hold flag is released
    typedef enum logic [0:0] {
        CLR_AT_START = 1'b0,
        CLR_AT_END   = 1'b1
    } clr_point_e;

    // One-cycle pulses for the two strobe edges after synchronisation
    typedef struct packed {
        logic lead;   // strobe went active
        logic trail;  // strobe went idle
    } strobe_evt_t;

    // Bus drive decision for the phantom line
    typedef struct packed {
        logic oe;
        logic level_n;
    } phantom_drive_t;

    function automatic phantom_drive_t make_drive(input logic hold, input logic req);
        phantom_drive_t d;
        d.oe      = hold | req;
        d.level_n = ~(hold | req);
        return d;
    endfunction

endpackage

// File: rtl/bsc_strobe_sync.sv
module bsc_strobe_sync
    import boot_shadow_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe_n,
    output strobe_evt_t evt
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;
    logic          level_n;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= strobe_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[LAST-1:0], strobe_n};
            end
        end
    endgenerate

    assign level_n = chain_q[LAST];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level_n;
    end

    assign evt.lead  = prev_q & ~level_n;
    assign evt.trail = ~prev_q & level_n;

    AST_LEAD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt.lead |=> !evt.lead);  // R2
    AST_TRAIL_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt.trail |=> !evt.trail);  // R7

endmodule

// File: rtl/bsc_window_decode.sv
module bsc_window_decode #(
    parameter int                ADDR_W = 16,
    parameter int                TAG_W  = 3,
    parameter logic [ADDR_W-1:0] BASE   = 16'hE000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_sel,
    input  logic              start,
    output logic              hit_now,
    output logic              hit_held
);
    localparam int TAG_MSB = ADDR_W - 1;
    localparam int TAG_LSB = ADDR_W - TAG_W;

    assign hit_now = win_sel && (addr[TAG_MSB:TAG_LSB] == BASE[TAG_MSB:TAG_LSB]);

    // Decision captured at the start of the access, used by the end-of-access variant
    always_ff @(posedge clk) begin
        if (rst)        hit_held <= 1'b0;
        else if (start) hit_held <= hit_now;
    end

    AST_HELD_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        (start && !win_sel) |=> !hit_held);  // R3

endmodule

// File: rtl/bsc_hold_flag.sv
module bsc_hold_flag #(
    parameter bit RESET_SETS = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic hold
);
    always_ff @(posedge clk) begin
        if (rst)      hold <= RESET_SETS;
        else if (clr) hold <= 1'b0;
    end

    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !hold |=> !hold);  // R4
    AST_CLEAR_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        (hold && !clr) |=> hold);  // R3

endmodule

// File: rtl/boot_shadow_ctrl.sv
module boot_shadow_ctrl
    import boot_shadow_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                WIN_TAG_W   = 3,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 16'hE000,
    parameter int                SYNC_STAGES = 2,
    parameter clr_point_e        CLR_POINT   = CLR_AT_START,
    parameter bit                RESET_SETS  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mreq_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_sel,
    input  logic              shadow_req,
    output logic              phantom_n,
    output logic              phantom_oe
);
    strobe_evt_t    evt;
    logic           hit_now;
    logic           hit_held;
    logic           clr_evt;
    logic           hold;
    phantom_drive_t drv;

    bsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (mreq_n),
        .evt      (evt)
    );

    bsc_window_decode #(.ADDR_W(ADDR_W), .TAG_W(WIN_TAG_W), .BASE(WIN_BASE)) u_win (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .win_sel  (win_sel),
        .start    (evt.lead),
        .hit_now  (hit_now),
        .hit_held (hit_held)
    );

    assign clr_evt = (CLR_POINT == CLR_AT_END) ? (evt.trail & hit_held)
                                               : (evt.lead  & hit_now);

    bsc_hold_flag #(.RESET_SETS(RESET_SETS)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_evt),
        .hold (hold)
    );

    assign drv        = make_drive(hold, shadow_req);
    assign phantom_oe = drv.oe;
    assign phantom_n  = drv.level_n;

    AST_DRIVE_ONLY_LOW: assert property (@(posedge clk)
        phantom_oe |-> !phantom_n);  // R6
    AST_REQUEST_FORCES: assert property (@(posedge clk) disable iff (rst)
        shadow_req |-> phantom_oe);  // R5

    generate
        if (RESET_SETS) begin : g_chk_set
            AST_ACTIVE_AFTER_RESET: assert property (@(posedge clk)
                $past(rst) |-> phantom_oe);  // R1
        end else begin : g_chk_noset
            AST_ONLY_REQUEST: assert property (@(posedge clk) disable iff (rst)
                phantom_oe == shadow_req);  // R8
        end
    endgenerate

endmodule

// File: tb/tb_boot_shadow_ctrl.sv
module tb_boot_shadow_ctrl;
    import boot_shadow_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        mreq_n;
    logic [15:0] addr;
    logic        win_sel;
    logic        shadow_req;
    logic        pn_l, oe_l, pn_t, oe_t, pn_z, oe_z;

    always #10 clk = ~clk;  // 50 MHz

    boot_shadow_ctrl dut (
        .clk(clk), .rst(rst), .mreq_n(mreq_n), .addr(addr), .win_sel(win_sel),
        .shadow_req(shadow_req), .phantom_n(pn_l), .phantom_oe(oe_l));

    boot_shadow_ctrl #(.CLR_POINT(CLR_AT_END)) dut_end (
        .clk(clk), .rst(rst), .mreq_n(mreq_n), .addr(addr), .win_sel(win_sel),
        .shadow_req(shadow_req), .phantom_n(pn_t), .phantom_oe(oe_t));

    boot_shadow_ctrl #(.RESET_SETS(1'b0)) dut_noset (
        .clk(clk), .rst(rst), .mreq_n(mreq_n), .addr(addr), .win_sel(win_sel),
        .shadow_req(shadow_req), .phantom_n(pn_z), .phantom_oe(oe_z));

    typedef struct {
        bit    lead;
        bit    trail;
        bit    noset;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_all(input bit l, input bit t, input bit z, input string tag);
        exp_t e;
        e.lead = l; e.trail = t; e.noset = z; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic cmp(input logic oe, input logic pn, input bit exp, input string tag,
                       input string which);
        n_chk++;
        if (oe !== exp || pn !== !exp) begin
            n_fail++;
            $display("FAIL %s [%s]: oe=%b phantom_n=%b, expected oe=%b phantom_n=%b",
                     tag, which, oe, pn, exp, !exp);
        end
    endtask

    // Monitor: compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                cmp(oe_l, pn_l, e.lead,  e.tag, "start-clear");
                cmp(oe_t, pn_t, e.trail, e.tag, "end-clear");
                cmp(oe_z, pn_z, e.noset, e.tag, "no-reset-set");
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            report();
        end
    end

    initial begin
        rst = 1'b1; mreq_n = 1'b1; addr = '0; win_sel = 1'b1; shadow_req = 1'b0;
        repeat (3) step();
        expect_all(1, 1, 0, "R1 R8 during reset");
        step(); rst = 1'b0;
        expect_all(1, 1, 0, "R1 first cycle after reset");
        step();
        expect_all(1, 1, 0, "R1 R6 idle after reset");

        // Just below the window
        step(); addr = 16'hDFFF; mreq_n = 1'b0;
        for (int i = 0; i < 4; i++) begin step(); expect_all(1, 1, 0, "R3 R10 0xDFFF active"); end
        step(); mreq_n = 1'b1;
        for (int i = 0; i < 4; i++) begin step(); expect_all(1, 1, 0, "R3 R10 0xDFFF ended"); end

        // In window but decode disabled
        step(); addr = 16'hE000; win_sel = 1'b0; mreq_n = 1'b0;
        for (int i = 0; i < 4; i++) begin step(); expect_all(1, 1, 0, "R3 select off active"); end
        step(); mreq_n = 1'b1;
        for (int i = 0; i < 4; i++) begin step(); expect_all(1, 1, 0, "R3 select off ended"); end
        win_sel = 1'b1;

        // Request alone
        step(); shadow_req = 1'b1; expect_all(1, 1, 1, "R5 R8 request while held");
        step(); shadow_req = 1'b0; expect_all(1, 1, 0, "R8 request released");

        // First qualified access at top of window
        step(); addr = 16'hFFFF; mreq_n = 1'b0;
        step(); expect_all(1, 1, 0, "R2 first sync stage");
        step(); expect_all(1, 1, 0, "R2 edge not yet applied");
        step(); addr = 16'h1000; expect_all(0, 1, 0, "R2 R10 clear at start");
        step(); expect_all(0, 1, 0, "R7 held during access");
        step(); expect_all(0, 1, 0, "R7 held during access");
        step(); mreq_n = 1'b1; expect_all(0, 1, 0, "R7 strobe released");
        step(); expect_all(0, 1, 0, "R7 first sync stage");
        step(); expect_all(0, 1, 0, "R7 edge not yet applied");
        step(); expect_all(0, 0, 0, "R7 clear at end");

        // Request after clear
        step(); shadow_req = 1'b1; expect_all(1, 1, 1, "R5 request after clear");
        step(); shadow_req = 1'b0; expect_all(0, 0, 0, "R5 R6 release after clear");

        // Further qualified access does not re-set
        step(); addr = 16'hE000; mreq_n = 1'b0;
        for (int i = 0; i < 5; i++) begin step(); expect_all(0, 0, 0, "R4 second access active"); end
        step(); mreq_n = 1'b1;
        for (int i = 0; i < 5; i++) begin step(); expect_all(0, 0, 0, "R4 second access ended"); end

        // Reset again
        step(); rst = 1'b1;
        step(); expect_all(1, 1, 0, "R1 R4 reset sets again");
        step(); rst = 1'b0; expect_all(1, 1, 0, "R1 after second reset");

        // Clear coinciding with request
        step(); shadow_req = 1'b1; addr = 16'hE000; mreq_n = 1'b0;
        expect_all(1, 1, 1, "R9 overlap start");
        for (int i = 0; i < 5; i++) begin step(); expect_all(1, 1, 1, "R9 overlap active"); end
        step(); mreq_n = 1'b1;
        for (int i = 0; i < 4; i++) begin step(); expect_all(1, 1, 1, "R9 overlap ended"); end
        step(); shadow_req = 1'b0; expect_all(0, 0, 0, "R9 cleared under request");

        step();
        @(negedge clk);
        #1;
        done = 1;
        report();
    end

endmodule